// File: doc/BRIEF.md
# External Interrupt Distributor

This block gathers a set of level-sensitive interrupt lines and delivers them to several processor contexts. Each source passes through a three-state gateway. In `GW_IDLE` it waits for its line. It moves IDLE→PEND when the line is seen high at a clock edge. In `GW_PEND` the source is eligible for delivery. It moves PEND→BUSY when some context claims it. In `GW_BUSY` the source is withheld from every context until a completion naming its ID moves it BUSY→IDLE. A source left in PEND stays there even if its line falls.

Each source has a small priority value. Each context has its own enable mask and a threshold. A per-context arbiter picks, among the pending sources it has enabled, the one with the highest priority that lies strictly above the threshold. The context's request line stays high while any such source exists. Software reaches every register through a single word-wide register bus. A read of a context's claim register returns the winning ID and moves that source into BUSY in the same cycle. Writing the ID back to the same register retires it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every priority, enable bit and threshold reads 0, every `ctx_irq` bit is low, and a claim read returns 0.
- R2: Source N (1..NSRC) has its priority at byte address 4*N, holding PRIO_W bits; wider write data is truncated. The word for ID 0 and any ID above NSRC reads 0.
- R3: Context c's enable bit for source N is bit N%32 of the word at 0x2000 + 0x80*c + 4*(N/32). These words are plain read/write with no side effects, and bit 0 of word 0 (ID 0) always reads 0.
- R4: Context c's threshold (PRIO_W bits) is at 0x200000 + 0x1000*c, and its claim/complete register is at that address plus 4.
- R5: `ctx_irq[c]` is high exactly when some source is pending, enabled for c, and has a priority strictly greater than threshold c. A source with priority 0 is never delivered.
- R6: A claim read returns the eligible source with the highest priority. On a tie it returns the lowest ID.
- R7: A claim read with no eligible source returns 0 and changes no state.
- R8: A claim removes the returned source from delivery at once. A claim by another context never returns it, and `ctx_irq` falls if no other eligible source remains.
- R9: Writing a claimed ID to any claim register retires it. If the source line is still high, the source becomes pending again at the next clock edge.
- R10: A completion write whose value is 0, above NSRC, or the ID of a source that is not claimed has no effect.
- R11: Reads of unimplemented addresses return 0, and writes to them change nothing.
- R12: Read data appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request. `bus_rvalid` stays low after writes.
- R13: A source line that pulses high for a single cycle stays pending until it is claimed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Marks `bus_rdata` valid |
| src_irq | input | NSRC (NSRC:1) | Level interrupt lines, bit N is source N |
| ctx_irq | output | NCTX | Interrupt request per context |

## Verification
The checker relies on one register access per cycle. Because of this, a claim and a completion never share an edge, and the number of sources held in BUSY changes by at most one per access. It also relies on completion values being compared as full 32-bit words. The directed tests issue each access from a task that holds `bus_valid` for exactly one cycle. They drive source lines only between clock edges, so every gateway transition happens on a known edge.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_PRIO  = 3'd1,
        RG_EN    = 3'd2,
        RG_THR   = 3'd3,
        RG_CLAIM = 3'd4
    } region_e;

    localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
    localparam logic [31:0] PRIO_END   = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam logic [11:0] OFF_THR    = 12'h000;
    localparam logic [11:0] OFF_CLAIM  = 12'h004;

endpackage

// File: rtl/eic_gateway.sv
module eic_gateway
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic grant,
    input  logic retire,
    output logic pend,
    output logic busy
);

    gw_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GW_IDLE: if (level)  st_d = GW_PEND;
            GW_PEND: if (grant)  st_d = GW_BUSY;
            GW_BUSY: if (retire) st_d = GW_IDLE;
            default:             st_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pend = (st_q == GW_PEND);
        busy = (st_q == GW_BUSY);
    end

endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             en,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic                      irq,
    output logic [ID_W-1:0]           win_id
);

    logic [PRIO_W-1:0] best_p;

    // strict compare keeps the lowest ID on equal priority
    always_comb begin
        best_p = '0;
        win_id = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > thr) && (prio[i] > best_p)) begin
                best_p = prio[i];
                win_id = ID_W'(i);
            end
        end
        irq = (win_id != '0);
    end

endmodule

// File: rtl/eic_decode.sv
module eic_decode
    import eic_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int ADDR_W = 26,
    parameter int ID_W   = 5,
    parameter int CTX_W  = 1,
    parameter int NWORDS = 1,
    parameter int EW_W   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ID_W-1:0]   src_id,
    output logic [CTX_W-1:0]  ctx,
    output logic [EW_W-1:0]   word
);

    localparam logic [31:0] EN_END  = EN_BASE + 32'(NCTX) * EN_STRIDE;
    localparam logic [31:0] CTX_END = CTX_BASE + 32'(NCTX) * CTX_STRIDE;

    logic [31:0] a;
    logic [31:0] off;
    logic [31:0] idx;

    always_comb begin
        a      = 32'(addr) & ~32'h3;
        region = RG_NONE;
        off    = '0;
        idx    = '0;
        src_id = '0;
        ctx    = '0;
        word   = '0;
        if (a < PRIO_END) begin
            idx    = (a - PRIO_BASE) >> 2;
            src_id = ID_W'(idx);
            if (idx >= 32'd1 && idx <= 32'(NSRC)) region = RG_PRIO;
        end else if (a >= EN_BASE && a < EN_END) begin
            off  = a - EN_BASE;
            ctx  = CTX_W'(off >> 7);
            idx  = {25'd0, off[6:2]};
            word = EW_W'(idx);
            if (idx < 32'(NWORDS)) region = RG_EN;
        end else if (a >= CTX_BASE && a < CTX_END) begin
            off = a - CTX_BASE;
            ctx = CTX_W'(off >> 12);
            if (off[11:0] == OFF_THR)        region = RG_THR;
            else if (off[11:0] == OFF_CLAIM) region = RG_CLAIM;
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [NSRC:1]     src_irq,
    output logic [NCTX-1:0]   ctx_irq
);

    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int NWORDS = (NSRC + 32) / 32;
    localparam int EW_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic [NSRC:1][PRIO_W-1:0] prio_q;
    logic [NCTX-1:0][NSRC:1]   en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [NCTX-1:0][ID_W-1:0] win_id;
    logic [NSRC:1]             gw_pend;
    logic [NSRC:1]             gw_busy;

    region_e          region;
    logic [ID_W-1:0]  dec_id;
    logic [CTX_W-1:0] dec_ctx;
    logic [EW_W-1:0]  dec_word;

    logic acc_rd, acc_wr, claim_rd, cmpl_wr, cmpl_ok;
    logic [ID_W-1:0] claim_id, cmpl_id;
    logic [31:0]     rdata_d;

    eic_decode #(
        .NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W),
        .ID_W(ID_W), .CTX_W(CTX_W), .NWORDS(NWORDS), .EW_W(EW_W)
    ) u_dec (
        .addr(bus_addr), .region(region), .src_id(dec_id),
        .ctx(dec_ctx), .word(dec_word)
    );

    always_comb begin
        acc_rd   = bus_valid && !bus_write;
        acc_wr   = bus_valid && bus_write;
        claim_rd = acc_rd && (region == RG_CLAIM);
        cmpl_wr  = acc_wr && (region == RG_CLAIM);
        claim_id = win_id[dec_ctx];
        cmpl_ok  = cmpl_wr && (bus_wdata >= 32'd1) && (bus_wdata <= 32'(NSRC));
        cmpl_id  = ID_W'(bus_wdata);
    end

    generate
        for (genvar i = 1; i <= NSRC; i++) begin : g_src
            logic grant_i, retire_i;
            assign grant_i  = claim_rd && (claim_id == ID_W'(i));
            assign retire_i = cmpl_ok && (cmpl_id == ID_W'(i));
            eic_gateway u_gw (
                .clk(clk), .rst_n(rst_n), .level(src_irq[i]),
                .grant(grant_i), .retire(retire_i),
                .pend(gw_pend[i]), .busy(gw_busy[i])
            );
        end

        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            eic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
                .pend(gw_pend), .en(en_q[c]), .prio(prio_q), .thr(thr_q[c]),
                .irq(ctx_irq[c]), .win_id(win_id[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (acc_wr) begin
            unique case (region)
                RG_PRIO: prio_q[dec_id] <= bus_wdata[PRIO_W-1:0];
                RG_EN: begin
                    for (int b = 0; b < 32; b++) begin
                        if ((32 * int'(dec_word) + b) >= 1 && (32 * int'(dec_word) + b) <= NSRC)
                            en_q[dec_ctx][32 * int'(dec_word) + b] <= bus_wdata[b];
                    end
                end
                RG_THR:  thr_q[dec_ctx] <= bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_d = '0;
        unique case (region)
            RG_PRIO: rdata_d = 32'(prio_q[dec_id]);
            RG_EN: begin
                for (int b = 0; b < 32; b++) begin
                    if ((32 * int'(dec_word) + b) >= 1 && (32 * int'(dec_word) + b) <= NSRC)
                        rdata_d[b] = en_q[dec_ctx][32 * int'(dec_word) + b];
                end
            end
            RG_THR:   rdata_d = 32'(thr_q[dec_ctx]);
            RG_CLAIM: rdata_d = 32'(claim_id);
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= acc_rd;
            if (acc_rd) bus_rdata <= rdata_d;
        end
    end

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
    parameter int NSRC = 31,
    parameter int NCTX = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 bus_rvalid,
    input logic [NCTX-1:0]      ctx_irq,
    input logic                 claim_rd,
    input logic                 cmpl_wr,
    input logic [((NCTX > 1) ? $clog2(NCTX) : 1)-1:0] acc_ctx,
    input logic [NSRC:1]        gw_pend,
    input logic [NSRC:1]        gw_busy
);

    logic tgt_busy;
    always_comb begin
        tgt_busy = 1'b0;
        for (int i = 1; i <= NSRC; i++)
            if (bus_wdata == 32'(i)) tgt_busy = gw_busy[i];
    end

    // R12
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R12
    no_wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    // R7
    empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !ctx_irq[acc_ctx]) |=> (bus_rdata == 32'd0));

    // R6
    claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && ctx_irq[acc_ctx]) |=> (bus_rdata != 32'd0));

    // R8
    claim_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && ctx_irq[acc_ctx]) |=>
        ($countones(gw_busy) == $past($countones(gw_busy)) + 1));

    // R10
    stray_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_wr && !tgt_busy) |=> $stable(gw_busy));

    // R5
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctx_irq) |-> (|gw_pend));

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ctx_irq(ctx_irq), .claim_rd(claim_rd), .cmpl_wr(cmpl_wr),
    .acc_ctx(dec_ctx), .gw_pend(gw_pend), .gw_busy(gw_busy)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;

    localparam int NSRC = 31;
    localparam int NCTX = 2;
    localparam int AW   = 26;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NSRC:1]   src_irq = '0;
    logic [NCTX-1:0] ctx_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ext_irq_ctrl #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(AW)) i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .src_irq(src_irq), .ctx_irq(ctx_irq)
    );

    function automatic logic [AW-1:0] a_prio(int n);
        return AW'(4 * n);
    endfunction
    function automatic logic [AW-1:0] a_en(int c, int w);
        return AW'(32'h2000 + 32'h80 * c + 4 * w);
    endfunction
    function automatic logic [AW-1:0] a_thr(int c);
        return AW'(32'h20_0000 + 32'h1000 * c);
    endfunction
    function automatic logic [AW-1:0] a_clm(int c);
        return AW'(32'h20_0004 + 32'h1000 * c);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_valid = 1'b0;
        check("R12", "rvalid after read", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic rd_chk(string req, string what, logic [AW-1:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, what, d, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        src_irq = '0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "ctx_irq after reset", 32'(ctx_irq), 32'd0);
        rd_chk("R1", "prio 5", a_prio(5), 32'd0);
        rd_chk("R1", "enable ctx1", a_en(1, 0), 32'd0);
        rd_chk("R1", "threshold ctx0", a_thr(0), 32'd0);
        rd_chk("R1", "claim ctx0", a_clm(0), 32'd0);
    endtask

    task automatic t_regs();
        do_reset();
        wr(a_prio(3), 32'd5);
        check("R12", "no rvalid after write", 32'(bus_rvalid), 32'd0);
        rd_chk("R2", "prio 3 readback", a_prio(3), 32'd5);
        wr(a_prio(3), 32'hFF);
        rd_chk("R2", "prio 3 truncated", a_prio(3), 32'd7);
        wr(a_prio(31), 32'd2);
        rd_chk("R2", "prio 31", a_prio(31), 32'd2);
        wr(a_prio(0), 32'd6);
        rd_chk("R2", "prio id0", a_prio(0), 32'd0);
        rd_chk("R2", "prio id40", a_prio(40), 32'd0);
        wr(a_en(1, 0), 32'hFFFF_FFFF);
        rd_chk("R3", "enable ctx1 all", a_en(1, 0), 32'hFFFF_FFFE);
        rd_chk("R3", "enable ctx0 untouched", a_en(0, 0), 32'd0);
        wr(a_en(1, 0), 32'h0000_0410);
        rd_chk("R3", "enable ctx1 rmw", a_en(1, 0), 32'h0000_0410);
        wr(a_thr(1), 32'd3);
        rd_chk("R4", "threshold ctx1", a_thr(1), 32'd3);
        rd_chk("R4", "threshold ctx0", a_thr(0), 32'd0);
        wr(AW'(32'h1000), 32'd7);
        rd_chk("R11", "hole 0x1000", AW'(32'h1000), 32'd0);
        wr(a_en(0, 1), 32'hFFFF_FFFF);
        rd_chk("R11", "enable word 1", a_en(0, 1), 32'd0);
        wr(AW'(32'h20_0008), 32'd5);
        rd_chk("R11", "ctx offset 8", AW'(32'h20_0008), 32'd0);
        wr(a_thr(2), 32'd4);
        rd_chk("R11", "ctx 2 threshold", a_thr(2), 32'd0);
        rd_chk("R11", "thr0 unchanged", a_thr(0), 32'd0);
        rd_chk("R11", "prio 3 unchanged", a_prio(3), 32'd7);
    endtask

    task automatic t_gate();
        do_reset();
        wr(a_prio(4), 32'd2);
        @(negedge clk); src_irq[4] = 1'b1;
        wait_cyc(2);
        check("R5", "not enabled", 32'(ctx_irq), 32'd0);
        wr(a_en(0, 0), 32'h10);
        check("R5", "enabled ctx0", 32'(ctx_irq), 32'b01);
        wr(a_thr(0), 32'd2);
        check("R5", "threshold equal", 32'(ctx_irq), 32'b00);
        wr(a_thr(0), 32'd1);
        check("R5", "threshold below", 32'(ctx_irq), 32'b01);
        wr(a_thr(0), 32'd0);
        wr(a_prio(4), 32'd0);
        check("R5", "priority zero", 32'(ctx_irq), 32'b00);
    endtask

    task automatic t_arb();
        do_reset();
        wr(a_en(0, 0), 32'hFFFF_FFFE);
        wr(a_prio(7), 32'd3);
        wr(a_prio(9), 32'd5);
        wr(a_prio(12), 32'd5);
        @(negedge clk);
        src_irq[7] = 1'b1; src_irq[9] = 1'b1; src_irq[12] = 1'b1;
        @(negedge clk);
        src_irq = '0;
        wait_cyc(1);
        rd_chk("R6", "first claim tie", a_clm(0), 32'd9);
        rd_chk("R6", "second claim", a_clm(0), 32'd12);
        rd_chk("R6", "third claim", a_clm(0), 32'd7);
        check("R8", "irq after all claimed", 32'(ctx_irq), 32'd0);
        rd_chk("R7", "empty claim", a_clm(0), 32'd0);
        rd_chk("R7", "prio 9 kept", a_prio(9), 32'd5);
    endtask

    task automatic t_cross();
        do_reset();
        wr(a_prio(5), 32'd1);
        wr(a_en(0, 0), 32'h20);
        wr(a_en(1, 0), 32'h20);
        @(negedge clk); src_irq[5] = 1'b1;
        wait_cyc(1);
        check("R5", "both contexts", 32'(ctx_irq), 32'b11);
        rd_chk("R8", "ctx1 claim", a_clm(1), 32'd5);
        check("R8", "irq drops", 32'(ctx_irq), 32'b00);
        rd_chk("R8", "ctx0 claim blocked", a_clm(0), 32'd0);
        wr(a_clm(0), 32'd6);
        wait_cyc(2);
        check("R10", "stray id", 32'(ctx_irq), 32'b00);
        wr(a_clm(0), 32'd0);
        wait_cyc(2);
        check("R10", "id zero", 32'(ctx_irq), 32'b00);
        wr(a_clm(0), 32'd37);
        wait_cyc(2);
        check("R10", "id out of range", 32'(ctx_irq), 32'b00);
        wr(a_clm(0), 32'd5);
        check("R9", "idle right after complete", 32'(ctx_irq), 32'b00);
        wait_cyc(1);
        check("R9", "re-pending", 32'(ctx_irq), 32'b11);
        rd_chk("R9", "claim again", a_clm(0), 32'd5);
        @(negedge clk); src_irq[5] = 1'b0;
        wr(a_clm(1), 32'd5);
        wait_cyc(2);
        check("R9", "line low stays idle", 32'(ctx_irq), 32'b00);
    endtask

    task automatic t_latch();
        do_reset();
        wr(a_prio(2), 32'd1);
        wr(a_en(1, 0), 32'h4);
        @(negedge clk); src_irq[2] = 1'b1;
        @(negedge clk); src_irq[2] = 1'b0;
        wait_cyc(3);
        check("R13", "pulse latched", 32'(ctx_irq), 32'b10);
        rd_chk("R13", "pulse claim", a_clm(1), 32'd2);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_gate();
        t_arb();
        t_cross();
        t_latch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule